// File: doc/BRIEF.md
# Serial ADC I/O and conversion sequencer

This block is the digital control core of a serial-access 12-bit successive-approximation converter. It alternates between two phases. In the I/O phase, framed by an active-low chip select and paced by an external serial clock, it shifts a 12-bit command word in and shifts the result of the previous conversion out, MSB first. At the end of the I/O phase it runs a successive-approximation loop paced by an internal oscillator. The loop presents trial codes to an external DAC and reads back one comparator bit per oscillator period. The two phases are pipelined: every I/O cycle returns the result of the conversion that came before it.

A single active-low status pin reports progress in one of two modes, chosen by the command word. In end-of-conversion mode it is low while a conversion is running. In interrupt mode it drops when a result is latched and stays low until the host starts the next transfer. The block runs on a single clock `clk`. Chip select and serial clock are sampled synchronously, and one edge detector stage turns their transitions into single-cycle events. The internal oscillator is modelled as `OSC_DIV` clock cycles per period. A conversion therefore lasts `START_DLY + (DW+1)*OSC_DIV + OSC_DIV/2` clock cycles, which is 56 at the default parameters.

The controller has seven states: `S_IDLE` (no transfer), `S_IO` (transfer running), `S_ARMED` (conversion done with chip select still low), `S_DELAY` (oscillator start-up), `S_SAMPLE` (one acquisition period), `S_SAR` (one period per result bit) and `S_LATCH` (half a period, then the result is stored). The transitions are as follows:
- Any state goes to `S_IO` on a chip-select fall.
- `S_IO` goes to `S_IDLE` on a chip-select rise, or to `S_DELAY` on the twelfth serial-clock fall.
- `S_ARMED` goes to `S_IO` on a serial-clock rise, or to `S_IDLE` on a chip-select rise.
- `S_DELAY` goes to `S_SAMPLE`, and `S_SAMPLE` goes to `S_SAR`, when their timers expire.
- `S_SAR` goes to `S_LATCH` after the LSB period.
- `S_LATCH` goes to `S_ARMED` if chip select is low, or to `S_IDLE` if it is high.

Top module: `adc_seq_top`

## Requirements
- R1: After reset `status_n` is 1, `chan_addr` and `ctrl_bits` are 0 (so the status pin is in end-of-conversion mode), and the first I/O cycle shifts out the code 0.
- R2: Only a 1-to-0 transition of `cs_n` seen after reset starts an I/O cycle. If `cs_n` is already low when reset is released, serial clocks have no effect: no conversion runs and `chan_addr` stays unchanged.
- R3: `sdi` is sampled on each `sclk` rising edge and the command word is assembled MSB first. Its first 4 bits form `chan_addr`, and the remaining 8 bits form `ctrl_bits`. The last bit received, `ctrl_bits[0]`, selects the status mode (1 = interrupt, 0 = end-of-conversion). Both fields are updated on the clock edge at which the twelfth `sclk` fall is seen.
- R4: When an I/O cycle is started by a `cs_n` fall, `sdo` presents the result MSB on the next clock edge. Each `sclk` fall that follows the 1st to 11th rising edges advances `sdo` to the next lower bit.
- R5: The twelfth `sclk` fall ends the I/O cycle and starts a conversion. The result of conversion N is shifted out during I/O cycle N+1, and the result register changes only when a conversion completes.
- R6: The conversion tests bits from MSB to LSB. `dac_code` shows the kept bits ORed with the bit under test, and the bit is kept when `cmp_hi` is 1. The first trial is therefore 0x800, and with an analog input of 0x9C4 the second trial is 0xC00. The stored result equals the input code for any monotonic comparator.
- R7: A conversion takes exactly `START_DLY + (DW+1)*OSC_DIV + OSC_DIV/2` clock cycles, which is 56 at the defaults, measured from the edge that ends the I/O cycle to the edge that latches the result.
- R8: In end-of-conversion mode, `status_n` goes to 0 on the edge that starts a conversion and returns to 1 on the edge that latches the result.
- R9: In interrupt mode, `status_n` stays 1 during the conversion and goes to 0 when the result is latched. A `cs_n` rise does not clear it. It returns to 1 on the next `cs_n` fall, or on the next `sclk` rise while `cs_n` is low.
- R10: If `cs_n` stays low through a conversion, the first `sclk` rise after completion puts the new result MSB on `sdo` and counts as the first of the 12 clocks of the next I/O cycle.
- R11: A `cs_n` rise before the twelfth fall abandons the I/O cycle: no conversion starts, and neither the configuration nor the result changes. A `cs_n` rise during a conversion does not stop it. A `cs_n` fall during a conversion abandons the conversion, keeps the old result and begins a new I/O cycle.
- R12: `sdo_oe` is 1 exactly when `cs_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the time base of the modelled oscillator |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select framing each I/O cycle |
| sclk | input | 1 | External serial clock |
| sdi | input | 1 | Serial command input, sampled on sclk rising edges |
| cmp_hi | input | 1 | Comparator decision: 1 when the analog input is at or above dac_code |
| sdo | output | 1 | Serial result output, MSB first |
| sdo_oe | output | 1 | Output enable for sdo (high impedance when 0) |
| status_n | output | 1 | Active-low end-of-conversion or interrupt status |
| dac_code | output | DW | Trial code driven to the DAC |
| chan_addr | output | AW | Channel address from the last completed I/O cycle |
| ctrl_bits | output | DW-AW | Control field from the last completed I/O cycle; bit 0 is the status mode |

## Verification
The embedded properties check the following on every cycle: the conversion length, that end-of-conversion status is low only in conversion states, that an interrupt falls only out of the latch state, that the result register moves only on a latch strobe, and that the serial bit counter stays in range. The bench scenarios alone show the following: the pipelined return of the previous result, the bit order on `sdo`, the SAR trial sequence against a modelled analog level, how each mode clears the status pin, the held-chip-select restart, and the effects of abandoning a transfer or a conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_IO,
        S_ARMED,
        S_DELAY,
        S_SAMPLE,
        S_SAR,
        S_LATCH
    } seq_state_t;

endpackage

// File: rtl/adc_seq_edges.sv
module adc_seq_edges #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    for (genvar g = 0; g < N; g++) begin : g_sig
        logic q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= 1'b0;
            end else begin
                q <= lvl[g];
            end
        end

        assign rise[g] = lvl[g] & ~q;
        assign fall[g] = q & ~lvl[g];
    end

endmodule

// File: rtl/adc_seq_io.sv
module adc_seq_io #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_active,
    input  logic          start_cs,
    input  logic          start_clk,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          sdi,
    input  logic [DW-1:0] result,
    output logic          sdo,
    output logic [DW-1:0] in_word,
    output logic          io_end
);

    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] LAST = CW'(DW);

    logic [DW-1:0] out_sr;
    logic [DW-1:0] in_sr;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sr <= '0;
            in_sr  <= '0;
            cnt    <= '0;
        end else if (start_cs) begin
            out_sr <= result;
            in_sr  <= '0;
            cnt    <= '0;
        end else if (start_clk) begin
            out_sr <= result;
            in_sr  <= {{(DW-1){1'b0}}, sdi};
            cnt    <= CW'(1);
        end else if (io_active) begin
            if (sclk_rise && (cnt < LAST)) begin
                in_sr <= {in_sr[DW-2:0], sdi};
                cnt   <= cnt + CW'(1);
            end
            if (sclk_fall && (cnt != '0) && (cnt < LAST)) begin
                out_sr <= {out_sr[DW-2:0], 1'b0};
            end
        end
    end

    assign sdo     = out_sr[DW-1];
    assign in_word = in_sr;
    assign io_end  = io_active && sclk_fall && (cnt == LAST);

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          trial_en,
    input  logic          decide,
    input  logic          latch,
    input  logic          cmp_hi,
    output logic [DW-1:0] dac_code,
    output logic [DW-1:0] result,
    output logic          last_bit
);

    localparam int IW = $clog2(DW);

    logic [DW-1:0] work;
    logic [DW-1:0] result_q;
    logic [IW-1:0] idx;
    logic [DW-1:0] probe;
    logic [DW-1:0] trial;

    assign probe = {{(DW-1){1'b0}}, 1'b1} << idx;
    assign trial = work | probe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work     <= '0;
            result_q <= '0;
            idx      <= IW'(DW - 1);
        end else begin
            if (init) begin
                work <= '0;
                idx  <= IW'(DW - 1);
            end else if (decide) begin
                if (cmp_hi) begin
                    work <= trial;
                end
                if (idx != '0) begin
                    idx <= idx - IW'(1);
                end
            end
            if (latch) begin
                result_q <= work;
            end
        end
    end

    assign dac_code = trial_en ? trial : work;
    assign result   = result_q;
    assign last_bit = (idx == '0);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(result_q));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DW        = 12,
    parameter int AW        = 4,
    parameter int OSC_DIV   = 4,
    parameter int START_DLY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             sclk_rise,
    input  logic             io_end,
    input  logic [DW-1:0]    in_word,
    input  logic             sar_last,
    output logic             io_active,
    output logic             start_cs,
    output logic             start_clk,
    output logic             sar_init,
    output logic             sar_trial_en,
    output logic             sar_decide,
    output logic             sar_latch,
    output logic             status_n,
    output logic [AW-1:0]    chan_addr,
    output logic [DW-AW-1:0] ctrl_bits
);

    localparam int HALF      = OSC_DIV / 2;
    localparam int CMAX      = (START_DLY > OSC_DIV) ? START_DLY : OSC_DIV;
    localparam int TW        = $clog2(CMAX + 1);
    localparam int CONV_CLKS = START_DLY + (DW + 1) * OSC_DIV + HALF;
    localparam int CCW       = $clog2(CONV_CLKS + 1);

    seq_state_t state, state_d;
    logic [TW-1:0] tcnt;
    logic [AW-1:0] cfg_addr;
    logic [DW-AW-1:0] cfg_ctrl;
    logic period_end;
    logic conv_start;
    logic int_mode;
    logic in_conv;
    logic nxt_conv;

    assign period_end = (tcnt == TW'(OSC_DIV - 1));
    assign int_mode   = cfg_ctrl[0];

    always_comb begin
        in_conv = (state == S_DELAY) || (state == S_SAMPLE) ||
                  (state == S_SAR) || (state == S_LATCH);
        nxt_conv = (state_d == S_DELAY) || (state_d == S_SAMPLE) ||
                   (state_d == S_SAR) || (state_d == S_LATCH);
    end

    // next-state decision
    always_comb begin
        state_d = state;
        if (cs_fall) begin
            state_d = S_IO;
        end else begin
            unique case (state)
                S_IDLE: begin
                    state_d = S_IDLE;
                end
                S_IO: begin
                    if (cs_rise) begin
                        state_d = S_IDLE;
                    end else if (io_end) begin
                        state_d = S_DELAY;
                    end
                end
                S_ARMED: begin
                    if (cs_rise) begin
                        state_d = S_IDLE;
                    end else if (sclk_rise) begin
                        state_d = S_IO;
                    end
                end
                S_DELAY: begin
                    if (tcnt == TW'(START_DLY - 1)) begin
                        state_d = S_SAMPLE;
                    end
                end
                S_SAMPLE: begin
                    if (period_end) begin
                        state_d = S_SAR;
                    end
                end
                S_SAR: begin
                    if (period_end && sar_last) begin
                        state_d = S_LATCH;
                    end
                end
                S_LATCH: begin
                    if (tcnt == TW'(HALF - 1)) begin
                        state_d = cs_n ? S_IDLE : S_ARMED;
                    end
                end
                default: begin
                    state_d = S_IDLE;
                end
            endcase
        end
    end

    // strobes to the datapath
    always_comb begin
        io_active    = (state == S_IO);
        start_cs     = cs_fall;
        start_clk    = !cs_fall && !cs_rise && (state == S_ARMED) && sclk_rise;
        conv_start   = !cs_fall && !cs_rise && (state == S_IO) && io_end;
        sar_init     = conv_start;
        sar_trial_en = (state == S_SAR);
        sar_decide   = !cs_fall && (state == S_SAR) && period_end;
        sar_latch    = !cs_fall && (state == S_LATCH) && (tcnt == TW'(HALF - 1));
    end

    // state register and phase timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            tcnt  <= '0;
        end else begin
            state <= state_d;
            if (!nxt_conv || (state_d != state) || (state == S_SAR && period_end)) begin
                tcnt <= '0;
            end else begin
                tcnt <= tcnt + TW'(1);
            end
        end
    end

    // registered outputs: status pin and configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_n <= 1'b1;
            cfg_addr <= '0;
            cfg_ctrl <= '0;
        end else if (cs_fall) begin
            status_n <= 1'b1;
        end else if (sar_latch) begin
            status_n <= !int_mode;
        end else if (conv_start) begin
            cfg_addr <= in_word[DW-1 -: AW];
            cfg_ctrl <= in_word[DW-AW-1:0];
            status_n <= in_word[0];
        end else if (sclk_rise && !cs_n && int_mode) begin
            status_n <= 1'b1;
        end
    end

    assign chan_addr = cfg_addr;
    assign ctrl_bits = cfg_ctrl;

    // conversion length watch
    logic [CCW-1:0] conv_clks;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_clks <= '0;
        end else if (in_conv && nxt_conv) begin
            conv_clks <= conv_clks + CCW'(1);
        end else begin
            conv_clks <= '0;
        end
    end

    // R7
    conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sar_latch |-> (conv_clks == CCW'(CONV_CLKS - 1)));

    // R8
    eoc_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_n && !int_mode) |-> in_conv);

    // R9
    int_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(status_n) && int_mode) |-> ($past(state) == S_LATCH));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
    parameter int DW        = 12,
    parameter int AW        = 4,
    parameter int OSC_DIV   = 4,
    parameter int START_DLY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdi,
    input  logic             cmp_hi,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             status_n,
    output logic [DW-1:0]    dac_code,
    output logic [AW-1:0]    chan_addr,
    output logic [DW-AW-1:0] ctrl_bits
);

    logic [1:0] ev_rise;
    logic [1:0] ev_fall;
    logic io_active, start_cs, start_clk;
    logic sar_init, sar_trial_en, sar_decide, sar_latch, sar_last;
    logic io_end;
    logic [DW-1:0] in_word;
    logic [DW-1:0] result;

    adc_seq_edges #(.N(2)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({cs_n, sclk}),
        .rise  (ev_rise),
        .fall  (ev_fall)
    );

    adc_seq_ctrl #(
        .DW(DW), .AW(AW), .OSC_DIV(OSC_DIV), .START_DLY(START_DLY)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .cs_fall      (ev_fall[1]),
        .cs_rise      (ev_rise[1]),
        .sclk_rise    (ev_rise[0]),
        .io_end       (io_end),
        .in_word      (in_word),
        .sar_last     (sar_last),
        .io_active    (io_active),
        .start_cs     (start_cs),
        .start_clk    (start_clk),
        .sar_init     (sar_init),
        .sar_trial_en (sar_trial_en),
        .sar_decide   (sar_decide),
        .sar_latch    (sar_latch),
        .status_n     (status_n),
        .chan_addr    (chan_addr),
        .ctrl_bits    (ctrl_bits)
    );

    adc_seq_io #(.DW(DW)) u_io (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_active (io_active),
        .start_cs  (start_cs),
        .start_clk (start_clk),
        .sclk_rise (ev_rise[0]),
        .sclk_fall (ev_fall[0]),
        .sdi       (sdi),
        .result    (result),
        .sdo       (sdo),
        .in_word   (in_word),
        .io_end    (io_end)
    );

    adc_seq_sar #(.DW(DW)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (sar_init),
        .trial_en (sar_trial_en),
        .decide   (sar_decide),
        .latch    (sar_latch),
        .cmp_hi   (cmp_hi),
        .dac_code (dac_code),
        .result   (result),
        .last_bit (sar_last)
    );

    assign sdo_oe = !cs_n;

endmodule

// File: tb/sim_adc_seq_top.sv
module sim_adc_seq_top;

    localparam int CLK_P     = 10;
    localparam int DW        = 12;
    localparam int AW        = 4;
    localparam int OSC_DIV   = 4;
    localparam int START_DLY = 2;
    localparam int CONV      = START_DLY + (DW + 1) * OSC_DIV + OSC_DIV / 2;

    logic clk = 1'b0;
    logic rst_n, cs_n, sclk, sdi, cmp_hi;
    logic sdo, sdo_oe, status_n;
    logic [DW-1:0] dac_code;
    logic [AW-1:0] chan_addr;
    logic [DW-AW-1:0] ctrl_bits;
    logic [DW-1:0] ana;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    assign cmp_hi = (ana >= dac_code);

    adc_seq_top #(
        .DW(DW), .AW(AW), .OSC_DIV(OSC_DIV), .START_DLY(START_DLY)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .cmp_hi(cmp_hi), .sdo(sdo), .sdo_oe(sdo_oe), .status_n(status_n),
        .dac_code(dac_code), .chan_addr(chan_addr), .ctrl_bits(ctrl_bits)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        tick();
    endtask

    task automatic cs_hi();
        cs_n = 1'b1;
        tick();
    endtask

    task automatic clk_rise(input logic b);
        sdi  = b;
        sclk = 1'b1;
        tick();
    endtask

    task automatic clk_fall();
        sclk = 1'b0;
        tick();
    endtask

    // how: 0 = start by cs fall, 1 = cs already fallen, 2 = cs held low
    task automatic io_frame(input logic [DW-1:0] w, input int how, output logic [DW-1:0] got);
        got = '0;
        if (how == 0) cs_lo();
        if (how != 2) got[DW-1] = sdo;
        for (int i = DW - 1; i >= 0; i--) begin
            clk_rise(w[i]);
            if (how == 2 && i == DW - 1) got[DW-1] = sdo;
            clk_fall();
            if (i > 0) got[i-1] = sdo;
        end
    endtask

    task automatic wait_conv(input logic lvl, output int len);
        len = 0;
        while (status_n == lvl && len < 1000) begin
            len++;
            tick();
        end
    endtask

    logic [DW-1:0] got;
    logic [DW-1:0] exp_res;
    logic [DW-1:0] w;
    int len;
    int lows;
    int dummy;

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R5 watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        dummy = $urandom(32'd2718);
        rst_n = 1'b0; cs_n = 1'b0; sclk = 1'b0; sdi = 1'b0; ana = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1 status", {31'd0, status_n}, 32'd1);
        check("R1 addr", {28'd0, chan_addr}, 32'd0);
        check("R1 ctrl", {24'd0, ctrl_bits}, 32'd0);
        check("R12 oe low cs", {31'd0, sdo_oe}, 32'd1);

        // R2: cs low since reset, clocks ignored
        for (int i = 0; i < DW; i++) begin
            clk_rise(1'b1);
            clk_fall();
        end
        lows = 0;
        for (int i = 0; i < CONV + 10; i++) begin
            if (status_n == 1'b0) lows++;
            tick();
        end
        check("R2 no conversion", lows, 32'd0);
        check("R2 addr", {28'd0, chan_addr}, 32'd0);
        cs_hi();
        check("R12 oe high cs", {31'd0, sdo_oe}, 32'd0);

        // first frame: reset result, EOC mode
        ana = 12'h5A3;
        io_frame({4'hA, 8'h00}, 0, got);
        check("R1 first result", got, 32'd0);
        check("R3 addr", {28'd0, chan_addr}, 32'hA);
        check("R8 eoc low at start", {31'd0, status_n}, 32'd0);
        wait_conv(1'b0, len);
        check("R7 eoc duration", len, CONV);
        exp_res = 12'h5A3;

        // INT mode frame, cs kept low during conversion
        cs_hi();
        ana = 12'h0FF;
        io_frame({4'h3, 8'h81}, 0, got);
        check("R4 R5 pipelined result", got, exp_res);
        check("R3 ctrl", {24'd0, ctrl_bits}, 32'h81);
        wait_conv(1'b1, len);
        check("R9 int high duration", len, CONV);
        check("R9 int low", {31'd0, status_n}, 32'd0);
        exp_res = 12'h0FF;
        cs_hi();
        repeat (5) tick();
        check("R9 cs rise keeps int", {31'd0, status_n}, 32'd0);
        cs_lo();
        check("R9 cs fall clears int", {31'd0, status_n}, 32'd1);

        // R6 trial sequence, EOC mode, this frame started by cs fall above
        ana = 12'h9C4;
        io_frame({4'h5, 8'h00}, 1, got);
        check("R5 result int frame", got, exp_res);
        repeat (START_DLY + OSC_DIV) tick();
        check("R6 first trial", {20'd0, dac_code}, 32'h800);
        repeat (OSC_DIV) tick();
        check("R6 second trial", {20'd0, dac_code}, 32'hC00);
        wait_conv(1'b0, len);
        exp_res = 12'h9C4;

        // R10 cs held low, EOC mode
        ana = 12'hFFF;
        io_frame({4'h6, 8'h00}, 2, got);
        check("R10 held result", got, exp_res);
        wait_conv(1'b0, len);
        check("R7 held duration", len, CONV);
        exp_res = 12'hFFF;

        // switch to INT with cs held low
        ana = 12'h000;
        io_frame({4'h7, 8'h01}, 2, got);
        check("R10 held result 2", got, exp_res);
        wait_conv(1'b1, len);
        exp_res = 12'h000;
        check("R9 int pending", {31'd0, status_n}, 32'd0);
        clk_rise(1'b0);
        check("R9 sclk rise clears int", {31'd0, status_n}, 32'd1);
        check("R10 msb after rise", {31'd0, sdo}, {31'd0, exp_res[DW-1]});
        clk_fall();
        for (int i = DW - 2; i >= 0; i--) begin
            clk_rise(1'b0);
            clk_fall();
        end
        ana = 12'h321;
        wait_conv(1'b0, len);
        check("R8 eoc mode restored", len, CONV);
        exp_res = 12'h321;
        cs_hi();

        // R11 short frame abandoned
        cs_lo();
        for (int i = 0; i < 5; i++) begin
            clk_rise(1'b1);
            clk_fall();
        end
        cs_hi();
        lows = 0;
        for (int i = 0; i < CONV + 10; i++) begin
            if (status_n == 1'b0) lows++;
            tick();
        end
        check("R11 short frame no conversion", lows, 32'd0);
        check("R11 addr kept", {28'd0, chan_addr}, 32'h0);

        // R11 conversion abandoned by cs fall, cs rise ignored
        ana = 12'hABC;
        io_frame({4'h9, 8'h00}, 0, got);
        check("R11 result after short frame", got, exp_res);
        cs_hi();
        repeat (10) tick();
        check("R11 cs rise keeps conversion", {31'd0, status_n}, 32'd0);
        cs_lo();
        check("R11 abort releases status", {31'd0, status_n}, 32'd1);
        ana = 12'h456;
        io_frame({4'hC, 8'h00}, 1, got);
        check("R11 old result kept", got, exp_res);
        check("R3 addr after abort", {28'd0, chan_addr}, 32'hC);
        wait_conv(1'b0, len);
        exp_res = 12'h456;

        // random frames
        for (int it = 0; it < 24; it++) begin
            int held;
            logic mode;
            held = int'($urandom % 2);
            mode = 1'($urandom % 2);
            w = {4'($urandom), 7'($urandom), mode};
            if (held == 0) cs_hi();
            io_frame(w, (held == 0) ? 0 : 2, got);
            check("R5 R6 random result", got, exp_res);
            check("R3 random addr", {28'd0, chan_addr}, {28'd0, w[DW-1 -: AW]});
            wait_conv(mode, len);
            check("R7 random duration", len, CONV);
            check("R8 R9 random end level", {31'd0, status_n}, {31'd0, ~mode});
            exp_res = ana;
            ana = 12'($urandom);
        end
        cs_hi();
        io_frame(12'h000, 0, got);
        check("R5 final result", got, exp_res);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule